// File: doc/BRIEF.md
# Atomic Shared Memory with Aliased Read-Modify-Write

A small word-organised memory shared by several processor ports. Each port can load and store words. It can also make the memory itself carry out an indivisible read-modify-write on a word. The operation is not a separate command field: it is chosen by which alias window of the address space the access falls in. Every window maps onto the same physical words. So one word can be read plainly, incremented, decremented, have bits set or cleared, or be test-and-set, just by adding a different window offset to its address. Firmware builds locks, counting semaphores, event flags and queue indices from these operations without any software locking.

A round-robin arbiter grants one port at a time. A granted access holds the memory for two cycles. In the first cycle the word is read and captured. In the second cycle the new value is written and the requester gets its acknowledge together with the word's prior value. No other access can slip between the read and the write.

Handshake: a requester raises its request with its address, write flag, data and byte mask, and holds them steady until it sees its acknowledge. It then drops the request before the next clock edge.

Top module: `atomic_shmem`

## Requirements
- R1: After reset, every acknowledge is low and every memory word reads as zero.
- R2: Address bits [PAW-1:AW] select the operation: 0 plain, 1 add, 2 subtract, 3 set bits, 4 clear bits, 5 test-and-set, and 6 or 7 plain read that never writes. Bits [AW-1:0] select the word, and every window reaches the same word.
- R3: A plain access with the write flag high replaces only the bytes whose mask bit is set (mask bit b covers data bits 8b+7..8b). A plain access with the write flag low leaves the word unchanged.
- R4: Add and subtract replace the word with old plus data, or old minus data, modulo 2^32.
- R5: Set bits ORs the data into the word, and clear bits clears the word's bits where data is one. All other bits are kept.
- R6: Test-and-set stores the value 1 into the word, whatever it held before.
- R7: The read data presented with an acknowledge is the word's value before that access. Atomic operations act on the full word and ignore both the byte mask and the write flag.
- R8: Among simultaneous requests, the port after the one served last (cyclically) wins. After reset, port 0 has the highest priority.
- R9: An acknowledge is one cycle long and one-hot. It arrives in the cycle after the grant edge, only for a port that was requesting in the previous cycle. Under continuous contention, acknowledges are exactly two cycles apart.
- R10: Concurrent operations on one word are serialised. The final value and each returned old value match applying them one by one in acknowledge order.
- R11: The memory array is written only in a cycle in which an acknowledge is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | NPORTS | Per-port request, held until acknowledged |
| we_i | input | NPORTS | Per-port write flag (used only by plain accesses) |
| addr_i | input | NPORTS x PAW | Per-port address: operation window on top, word index below; PAW = clog2(DEPTH)+3 |
| wdata_i | input | NPORTS x 32 | Per-port store data or operand |
| be_i | input | NPORTS x 4 | Per-port byte mask for plain stores |
| ack_o | output | NPORTS | One-cycle acknowledge, one-hot |
| rdata_o | output | 32 | Word value before the acknowledged access |

## Verification
The hardest cases are several ports hitting the same word at once. All four ports test-and-set one lock: exactly one must see zero. A design that let a read slip between another port's read and write would hand the lock to two ports, or lose increments when four ports add to one counter. A fixed-priority or mis-rotated arbiter shows up in the acknowledge order when all ports request together from reset. A design that widened an operation to three cycles, or skipped one, breaks the two-cycle acknowledge spacing. A partial-store or alias-decode error shows up in byte-masked stores, in atomics issued with the write flag low or a zero mask, and in stores to the reserved windows. Each of these would leave a wrong word behind, and a plain read of that word exposes it.

// File: rtl/atomic_shmem_pkg.sv
`timescale 1ns/1ps
package atomic_shmem_pkg;

    localparam int OP_BITS = 3;
    localparam int DATA_W  = 32;
    localparam int BE_W    = DATA_W / 8;

    typedef enum logic [OP_BITS-1:0] {
        OP_PLAIN = 3'd0,
        OP_ADD   = 3'd1,
        OP_SUB   = 3'd2,
        OP_SETB  = 3'd3,
        OP_CLRB  = 3'd4,
        OP_TAS   = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } amo_op_e;

    typedef enum logic {
        PH_GRANT  = 1'b0,
        PH_UPDATE = 1'b1
    } phase_e;

endpackage

// File: rtl/shmem_rr_arb.sv
`timescale 1ns/1ps
module shmem_rr_arb #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    input  logic [IW-1:0] last_i,
    output logic          valid_o,
    output logic [IW-1:0] idx_o
);

    // Search starts one past the last winner and wraps around.
    always_comb begin
        logic [IW-1:0] cand;
        valid_o = 1'b0;
        idx_o   = '0;
        for (int k = 1; k <= N; k++) begin
            cand = IW'((int'(last_i) + k) % N);
            if (!valid_o && req_i[cand]) begin
                valid_o = 1'b1;
                idx_o   = cand;
            end
        end
    end

endmodule

// File: rtl/shmem_rmw_alu.sv
`timescale 1ns/1ps
module shmem_rmw_alu
    import atomic_shmem_pkg::*;
(
    input  amo_op_e           op_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] old_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [BE_W-1:0]   be_i,
    output logic [DATA_W-1:0] new_o,
    output logic              wr_o
);

    always_comb begin
        new_o = old_i;
        wr_o  = 1'b1;
        unique case (op_i)
            OP_PLAIN: begin
                wr_o = we_i;
                for (int b = 0; b < BE_W; b++) begin
                    if (be_i[b]) new_o[8*b +: 8] = operand_i[8*b +: 8];
                end
            end
            OP_ADD:  new_o = old_i + operand_i;
            OP_SUB:  new_o = old_i - operand_i;
            OP_SETB: new_o = old_i | operand_i;
            OP_CLRB: new_o = old_i & ~operand_i;
            OP_TAS:  new_o = DATA_W'(1);
            default: wr_o  = 1'b0;
        endcase
    end

endmodule

// File: rtl/atomic_shmem.sv
`timescale 1ns/1ps
module atomic_shmem
    import atomic_shmem_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int DEPTH  = 256,
    localparam int AW  = $clog2(DEPTH),
    localparam int PAW = AW + OP_BITS,
    localparam int PW  = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic [NPORTS-1:0]             req_i,
    input  logic [NPORTS-1:0]             we_i,
    input  logic [NPORTS-1:0][PAW-1:0]    addr_i,
    input  logic [NPORTS-1:0][DATA_W-1:0] wdata_i,
    input  logic [NPORTS-1:0][BE_W-1:0]   be_i,
    output logic [NPORTS-1:0]             ack_o,
    output logic [DATA_W-1:0]             rdata_o
);

    typedef struct packed {
        phase_e            phase;
        logic [PW-1:0]     port;
        amo_op_e           op;
        logic              we;
        logic [AW-1:0]     word;
        logic [DATA_W-1:0] operand;
        logic [BE_W-1:0]   be;
        logic [DATA_W-1:0] old;
    } ctrl_t;

    ctrl_t             ctl_d, ctl_q;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic              mem_we;
    logic [DATA_W-1:0] mem_wdata;

    logic              win_valid;
    logic [PW-1:0]     win_idx;
    logic [DATA_W-1:0] alu_new;
    logic              alu_wr;

    shmem_rr_arb #(.N(NPORTS)) u_arb (
        .req_i   (req_i),
        .last_i  (ctl_q.port),
        .valid_o (win_valid),
        .idx_o   (win_idx)
    );

    shmem_rmw_alu u_alu (
        .op_i      (ctl_q.op),
        .we_i      (ctl_q.we),
        .old_i     (ctl_q.old),
        .operand_i (ctl_q.operand),
        .be_i      (ctl_q.be),
        .new_o     (alu_new),
        .wr_o      (alu_wr)
    );

    // Phase 1 captures the winner and the old word; phase 2 writes back and acknowledges.
    always_comb begin
        ctl_d     = ctl_q;
        mem_we    = 1'b0;
        mem_wdata = alu_new;
        unique case (ctl_q.phase)
            PH_GRANT: begin
                if (win_valid) begin
                    ctl_d.phase   = PH_UPDATE;
                    ctl_d.port    = win_idx;
                    ctl_d.op      = amo_op_e'(addr_i[win_idx][PAW-1 -: OP_BITS]);
                    ctl_d.we      = we_i[win_idx];
                    ctl_d.word    = addr_i[win_idx][AW-1:0];
                    ctl_d.operand = wdata_i[win_idx];
                    ctl_d.be      = be_i[win_idx];
                    ctl_d.old     = mem_q[addr_i[win_idx][AW-1:0]];
                end
            end
            default: begin
                mem_we      = alu_wr;
                ctl_d.phase = PH_GRANT;
            end
        endcase
    end

    always_comb begin
        ack_o = '0;
        if (ctl_q.phase == PH_UPDATE) ack_o[ctl_q.port] = 1'b1;
    end

    assign rdata_o = ctl_q.old;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctl_q      <= '0;
            ctl_q.port <= PW'(NPORTS - 1);
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (mem_we) begin
            mem_q[ctl_q.word] <= mem_wdata;
        end
    end

endmodule

// File: rtl/atomic_shmem_chk.sv
`timescale 1ns/1ps
module atomic_shmem_chk #(
    parameter int NPORTS = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [NPORTS-1:0] req_i,
    input logic [NPORTS-1:0] ack_o,
    input logic              mem_we
);

    AST_ACK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(ack_o)); // R9

    AST_ACK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|ack_o) |=> !(|ack_o)); // R9

    AST_WRITE_IN_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_we |-> (|ack_o)); // R11

    for (genvar g = 0; g < NPORTS; g++) begin : g_port
        AST_ACK_FROM_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ack_o[g] |-> $past(req_i[g])); // R9
    end

endmodule

bind atomic_shmem atomic_shmem_chk #(.NPORTS(NPORTS)) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .ack_o  (ack_o),
    .mem_we (mem_we)
);

// File: tb/atomic_shmem_bench.sv
`timescale 1ns/1ps
module atomic_shmem_bench;

    localparam int NP    = 4;
    localparam int DEPTH = 256;
    localparam int AW    = 8;
    localparam int PAW   = AW + 3;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [NP-1:0]           req = '0;
    logic [NP-1:0]           we = '0;
    logic [NP-1:0][PAW-1:0]  addr = '0;
    logic [NP-1:0][31:0]     wd = '0;
    logic [NP-1:0][3:0]      be = '0;
    logic [NP-1:0]           ack;
    logic [31:0]             rdata;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;
    logic [31:0] model [DEPTH];
    int ord [0:63];
    int ord_cyc [0:63];
    int ord_n = 0;

    atomic_shmem #(.NPORTS(NP), .DEPTH(DEPTH)) u_atomic_shmem (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
        .wdata_i(wd), .be_i(be), .ack_o(ack), .rdata_o(rdata)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference behaviour of one access: {write, new value}
    function automatic logic [32:0] model_apply(input logic [2:0] op, input logic w,
            input logic [31:0] old, input logic [31:0] d, input logic [3:0] m);
        logic [31:0] n;
        n = old;
        case (op)
            3'd0: begin
                for (int b = 0; b < 4; b++) if (m[b]) n[8*b +: 8] = d[8*b +: 8];
                return {w, n};
            end
            3'd1: return {1'b1, old + d};
            3'd2: return {1'b1, old - d};
            3'd3: return {1'b1, old | d};
            3'd4: return {1'b1, old & ~d};
            3'd5: return {1'b1, 32'd1};
            default: return {1'b0, old};
        endcase
    endfunction

    task automatic access(input int p, input logic [2:0] op, input logic [7:0] w,
            input logic wr, input logic [31:0] d, input logic [3:0] m, output logic [31:0] rd);
        addr[p] = {op, w};
        we[p]   = wr;
        wd[p]   = d;
        be[p]   = m;
        req[p]  = 1'b1;
        do @(negedge clk); while (!ack[p]);
        rd = rdata;
        req[p] = 1'b0;
        @(negedge clk);
    endtask

    // Scoreboard: every acknowledge is replayed on the model in acknowledge order (R7, R10)
    always @(negedge clk) begin
        if (rst_n && (ack != '0)) begin
            logic [32:0] r;
            int p;
            p = 0;
            for (int i = 0; i < NP; i++) if (ack[i]) p = i;
            chk("R9 ack one-hot", 32'($countones(ack)), 32'd1);
            chk("R10 old value", rdata, model[addr[p][7:0]]);
            r = model_apply(addr[p][10:8], we[p], model[addr[p][7:0]], wd[p], be[p]);
            if (r[32]) model[addr[p][7:0]] = r[31:0];
            if (ord_n < 64) begin
                ord[ord_n] = p;
                ord_cyc[ord_n] = cyc;
                ord_n++;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] tas_rd [NP];
        int zeros;
        void'($urandom(32'h1357));
        for (int i = 0; i < DEPTH; i++) model[i] = '0;

        repeat (3) @(negedge clk);
        chk("R1 ack low in reset", 32'(ack), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ack low after reset", 32'(ack), 32'd0);

        // R8 / R9: all ports contend from reset, two reads each
        for (int p = 0; p < NP; p++) begin
            automatic int pp = p;
            fork
                begin
                    logic [31:0] x;
                    access(pp, 3'd0, 8'd0, 1'b0, 32'hFFFF_FFFF, 4'hF, x);
                    chk("R1 word reads zero", x, 32'd0);
                    access(pp, 3'd0, 8'd0, 1'b0, 32'h0, 4'hF, x);
                end
            join_none
        end
        wait fork;
        chk("R8 ack count", 32'(ord_n), 32'd8);
        for (int k = 0; k < 8; k++) chk("R8 round-robin order", 32'(ord[k]), 32'(k % NP));
        for (int k = 1; k < 8; k++) chk("R9 two-cycle spacing", 32'(ord_cyc[k] - ord_cyc[k-1]), 32'd2);

        // R4: add/sub with wrap
        access(0, 3'd0, 8'd5, 1'b1, 32'h10, 4'hF, rd);
        access(1, 3'd1, 8'd5, 1'b1, 32'h5, 4'hF, rd);
        chk("R7 add returns old", rd, 32'h10);
        access(2, 3'd2, 8'd5, 1'b1, 32'h20, 4'hF, rd);
        chk("R4 sub returns old after add", rd, 32'h15);
        access(3, 3'd0, 8'd5, 1'b0, 32'h0, 4'hF, rd);
        chk("R4 sub wraps modulo 2^32", rd, 32'hFFFF_FFF5);

        // R5: bit set and clear, through the same word via different windows (R2)
        access(0, 3'd0, 8'd6, 1'b1, 32'h1234_5678, 4'hF, rd);
        access(0, 3'd3, 8'd6, 1'b1, 32'h8000_0001, 4'hF, rd);
        chk("R5 set returns old", rd, 32'h1234_5678);
        access(1, 3'd4, 8'd6, 1'b1, 32'h0000_0070, 4'hF, rd);
        chk("R5 clear returns old", rd, 32'h9234_5679);
        access(1, 3'd0, 8'd6, 1'b0, 32'h0, 4'h0, rd);
        chk("R5 final bits", rd, 32'h9234_5609);

        // R6: test-and-set
        access(2, 3'd5, 8'd7, 1'b1, 32'hDEAD_BEEF, 4'hF, rd);
        chk("R6 first tas old", rd, 32'd0);
        access(3, 3'd5, 8'd7, 1'b1, 32'h0, 4'hF, rd);
        chk("R6 second tas old", rd, 32'd1);

        // R3: byte mask, plain read leaves word; R2: reserved window never writes
        access(0, 3'd0, 8'd8, 1'b1, 32'hAABB_CCDD, 4'hF, rd);
        access(0, 3'd0, 8'd8, 1'b1, 32'h1122_3344, 4'b0101, rd);
        access(0, 3'd0, 8'd8, 1'b0, 32'h5555_5555, 4'hF, rd);
        chk("R3 byte-masked store", rd, 32'hAA22_CC44);
        access(1, 3'd6, 8'd8, 1'b1, 32'hFFFF_FFFF, 4'hF, rd);
        chk("R2 reserved window reads", rd, 32'hAA22_CC44);
        access(1, 3'd7, 8'd8, 1'b1, 32'h0, 4'hF, rd);
        access(1, 3'd0, 8'd8, 1'b0, 32'h0, 4'hF, rd);
        chk("R2 reserved windows no write; R3 read no write", rd, 32'hAA22_CC44);

        // R7: atomics ignore write flag and byte mask
        access(2, 3'd1, 8'd9, 1'b0, 32'h3, 4'h0, rd);
        access(2, 3'd0, 8'd9, 1'b0, 32'h0, 4'hF, rd);
        chk("R7 add with we=0 mask=0", rd, 32'h3);

        // R10: contended lock and counter
        for (int p = 0; p < NP; p++) begin
            automatic int pp = p;
            fork
                begin
                    logic [31:0] x;
                    access(pp, 3'd5, 8'd12, 1'b1, 32'h0, 4'hF, x);
                    tas_rd[pp] = x;
                    access(pp, 3'd1, 8'd13, 1'b1, 32'h5, 4'hF, x);
                end
            join_none
        end
        wait fork;
        zeros = 0;
        for (int p = 0; p < NP; p++) if (tas_rd[p] == 32'd0) zeros++;
        chk("R10 exactly one lock winner", 32'(zeros), 32'd1);
        access(0, 3'd0, 8'd13, 1'b0, 32'h0, 4'hF, rd);
        chk("R10 contended counter", rd, 32'd20);

        // R10: random contention on a few words, scoreboard checks every ack
        for (int it = 0; it < 300; it++) begin
            for (int p = 0; p < NP; p++) begin
                automatic int pp = p;
                fork
                    begin
                        logic [31:0] x;
                        if (($urandom % 4) != 0)
                            access(pp, 3'($urandom % 8), 8'(40 + $urandom % 4), 1'($urandom % 2),
                                   $urandom, 4'($urandom % 16), x);
                    end
                join_none
            end
            wait fork;
        end
        for (int w = 40; w < 44; w++) begin
            access(0, 3'd0, 8'(w), 1'b0, 32'h0, 4'hF, rd);
            chk("R10 final random word", rd, model[w]);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule